// File: doc/BRIEF.md
# Eight-Channel Countdown Timer Bank

This block holds a set of independent 32-bit down-counters behind a simple APB-style register port. Software gives each channel a reload value and a control word. The channel then counts down once per clock. Each time it passes through zero it raises an interrupt flag and starts a new period. There are two period modes. One reloads from the programmed value. The other wraps to all-ones and keeps running.

Each channel drives its own interrupt line. That line is the channel's raw flag gated by the channel's mask bit. Interrupts are acknowledged by reading, not writing. A read of a channel's end-of-interrupt word clears that channel alone. A read of the shared end-of-interrupt word clears every channel at once. A shared region also gives a one-word view of all flags, both before and after masking, so a handler can find its sources with a single read.

The bus uses one setup cycle (`psel` high, `penable` low) followed by one access cycle (`psel` and `penable` both high). A write or a read side effect takes effect at the clock edge that ends the access cycle. `prdata` is combinational and valid while `psel` is high. The port never inserts wait states.

Top module: `countdown_bank`

## Requirements
- R1: Channel n owns byte addresses n*0x14 to n*0x14+0x13. Within that window the word offsets are: 0x00 reload value (read/write), 0x04 live count (read-only), 0x08 control (read/write), 0x0C end-of-interrupt (read-only, bit 0 returns the raw flag), 0x10 masked status (bit 0). Any byte address that is not one of these words, and not one of the shared words in R10 and R8, reads as zero.
- R2: After reset, every control word, reload value and live count is zero, every interrupt flag is clear, and all `irq` lines are low.
- R3: The control word has four fields: bit 0 run enable, bit 1 period mode (1 = reload from the reload value, 0 = wrap), bit 2 interrupt mask (1 = masked), and bit 4 trigger enable. The trigger enable bit is stored and read back but has no effect on counting. All other control bits read as zero.
- R4: When run enable goes from 0 to 1, the live count takes the reload value on the next clock. From then on it decrements by one per clock. With a reload value of L, the raw flag is first set L+2 clocks after the edge that wrote the control word.
- R5: In reload mode, the clock after the count reaches zero sets the raw flag and reloads the count from the reload value. A reload value written while the channel is running does not change the live count; it is first used at the next reload.
- R6: In wrap mode, the clock after the count reaches zero sets the raw flag and sets the count to 0xFFFFFFFF.
- R7: While run enable is 0, the live count holds its value.
- R8: A channel's status bit and its `irq` line are high exactly when its raw flag is set and its mask bit is clear. The shared word at 0xA8 shows the raw flags, with bit n belonging to channel n, whatever the masks are. The shared word at 0xA0 shows the masked flags in the same bit order.
- R9: A read of a channel's end-of-interrupt word clears only that channel's raw flag. If a zero crossing sets the flag in the same cycle as the read, the flag stays set.
- R10: A read of the shared word at 0xA4 returns the masked flag vector and clears the raw flags of all channels.
- R11: Writes to the live count, end-of-interrupt, status and shared words are ignored. In particular, such a write clears no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Transfer select (setup and access cycles) |
| penable | input | 1 | Access cycle marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while psel is high |
| irq | output | 8 | Per-channel masked interrupt lines |

## Verification
The hardest situation to reach from the ports is a reload value that changes while a channel is mid-period. The old value must stay in force until the zero crossing, and only then may the new value be used. The bench reaches this state by starting a long period and rewriting the reload value part-way through. It then reads the live count once, to show that the count was untouched. It reads the count again one clock after the interrupt appears, to show that the count restarted from the new value. The start-up latency is swept for every channel over a range of small reload values, and every byte address is read after each channel's reload value has been set to a distinct pattern.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  // byte span of one channel window
  localparam int WIN_BYTES = 20;
  // word offsets inside a channel window
  localparam int OFS_LOAD  = 0;
  localparam int OFS_CUR   = 4;
  localparam int OFS_CTRL  = 8;
  localparam int OFS_EOI   = 12;
  localparam int OFS_STAT  = 16;
  // shared words
  localparam int GLB_MSK   = 'hA0;
  localparam int GLB_EOI   = 'hA4;
  localparam int GLB_RAW   = 'hA8;

  typedef struct packed {
    logic trig;
    logic mask;
    logic mode;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/cdt_decode.sv
module cdt_decode
  import cdt_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_CH-1:0] sel_load,
  output logic [NUM_CH-1:0] sel_cur,
  output logic [NUM_CH-1:0] sel_ctrl,
  output logic [NUM_CH-1:0] sel_eoi,
  output logic [NUM_CH-1:0] sel_stat,
  output logic              sel_gmsk,
  output logic              sel_geoi,
  output logic              sel_graw
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int BASE = c * WIN_BYTES;
    assign sel_load[c] = (addr == ADDR_W'(BASE + OFS_LOAD));
    assign sel_cur[c]  = (addr == ADDR_W'(BASE + OFS_CUR));
    assign sel_ctrl[c] = (addr == ADDR_W'(BASE + OFS_CTRL));
    assign sel_eoi[c]  = (addr == ADDR_W'(BASE + OFS_EOI));
    assign sel_stat[c] = (addr == ADDR_W'(BASE + OFS_STAT));
  end

  assign sel_gmsk = (addr == ADDR_W'(GLB_MSK));
  assign sel_geoi = (addr == ADDR_W'(GLB_EOI));
  assign sel_graw = (addr == ADDR_W'(GLB_RAW));
endmodule

// File: rtl/cdt_chan.sv
module cdt_chan
  import cdt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_load,
  input  logic             wr_ctrl,
  input  logic [CNT_W-1:0] wdata,
  input  logic             clr,
  output logic [CNT_W-1:0] load_q,
  output logic [CNT_W-1:0] cnt_q,
  output ctrl_t            ctrl_q,
  output logic             raw_q
);
  logic run_q;
  logic hit;

  // zero crossing of a running channel
  assign hit = ctrl_q.en && run_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr_load) load_q <= wdata;
      if (wr_ctrl) ctrl_q <= '{trig: wdata[4], mask: wdata[2],
                                mode: wdata[1], en: wdata[0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (!ctrl_q.en) begin
      run_q <= 1'b0;
    end else if (!run_q) begin
      cnt_q <= load_q;
      run_q <= 1'b1;
    end else if (hit) begin
      cnt_q <= ctrl_q.mode ? load_q : '1;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // a new crossing wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    raw_q <= 1'b0;
    else if (hit)  raw_q <= 1'b1;
    else if (clr)  raw_q <= 1'b0;
  end

  // R7
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ctrl_q.en) |-> cnt_q == $past(cnt_q));
  // R4
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctrl_q.en && !run_q) |-> cnt_q == $past(load_q));
  // R4
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctrl_q.en && run_q && cnt_q != '0) |-> cnt_q == $past(cnt_q) - 1'b1);
  // R5
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hit && ctrl_q.mode) |-> (cnt_q == $past(load_q)) && raw_q);
  // R6
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hit && !ctrl_q.mode) |-> (cnt_q == '1) && raw_q);
  // R9
  raw_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr && !hit) |-> !raw_q);
endmodule

// File: rtl/countdown_bank.sv
module countdown_bank
  import cdt_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [CNT_W-1:0]  pwdata,
  output logic [CNT_W-1:0]  prdata,
  output logic [NUM_CH-1:0] irq
);
  localparam int PAD_W = CNT_W - NUM_CH;

  logic acc, wr_acc, rd_acc;
  logic [NUM_CH-1:0] sel_load, sel_cur, sel_ctrl, sel_eoi, sel_stat;
  logic sel_gmsk, sel_geoi, sel_graw;
  logic [CNT_W-1:0] load_a [NUM_CH];
  logic [CNT_W-1:0] cnt_a  [NUM_CH];
  ctrl_t            ctrl_a [NUM_CH];
  logic [NUM_CH-1:0] raw_v, msk_v, clr_v;

  assign acc    = psel && penable;
  assign wr_acc = acc && pwrite;
  assign rd_acc = acc && !pwrite;

  cdt_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) dec_i (
    .addr(paddr), .sel_load(sel_load), .sel_cur(sel_cur), .sel_ctrl(sel_ctrl),
    .sel_eoi(sel_eoi), .sel_stat(sel_stat), .sel_gmsk(sel_gmsk),
    .sel_geoi(sel_geoi), .sel_graw(sel_graw)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign clr_v[c] = rd_acc && (sel_eoi[c] || sel_geoi);
    cdt_chan #(.CNT_W(CNT_W)) chan_i (
      .clk(clk), .rst_n(rst_n),
      .wr_load(wr_acc && sel_load[c]),
      .wr_ctrl(wr_acc && sel_ctrl[c]),
      .wdata(pwdata), .clr(clr_v[c]),
      .load_q(load_a[c]), .cnt_q(cnt_a[c]), .ctrl_q(ctrl_a[c]),
      .raw_q(raw_v[c])
    );
    assign msk_v[c] = raw_v[c] && !ctrl_a[c].mask;
  end

  assign irq = msk_v;

  always_comb begin
    prdata = '0;
    if (psel) begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (sel_load[i]) prdata = prdata | load_a[i];
        if (sel_cur[i])  prdata = prdata | cnt_a[i];
        if (sel_ctrl[i]) prdata = prdata | CNT_W'({ctrl_a[i].trig, 1'b0,
                                 ctrl_a[i].mask, ctrl_a[i].mode, ctrl_a[i].en});
        if (sel_eoi[i])  prdata = prdata | CNT_W'(raw_v[i]);
        if (sel_stat[i]) prdata = prdata | CNT_W'(msk_v[i]);
      end
      if (sel_gmsk || sel_geoi) prdata = prdata | {{PAD_W{1'b0}}, msk_v};
      if (sel_graw)             prdata = prdata | {{PAD_W{1'b0}}, raw_v};
    end
  end

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & ~raw_v) == '0);
  // R10
  glb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_acc && sel_geoi) |-> $countones(raw_v) <= $countones($past(raw_v)));
endmodule

// File: tb/countdown_bank_tb_top.sv
module countdown_bank_tb_top;
  localparam int NCH = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [NCH-1:0] irq;
  int nchk = 0;
  int nfail = 0;

  always #4 clk = ~clk;

  countdown_bank dut_i (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq)
  );

  function automatic logic [7:0] ca(int c, int ofs);
    return 8'(c * 20 + ofs);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // called at a negedge, returns at the negedge after the committing edge
  task automatic bwr(logic [7:0] a, logic [31:0] d);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(posedge clk); @(negedge clk);
    penable = 1'b1;
    @(posedge clk); @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic brd(logic [7:0] a, output logic [31:0] d);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(posedge clk); @(negedge clk);
    penable = 1'b1;
    #1 d = prdata;
    @(posedge clk); @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic wait_irq(int c, int lim, output int k);
    k = 0;
    while (!irq[c] && k < lim) begin
      @(posedge clk); @(negedge clk);
      k++;
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d, v1, v2;
    int k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: reset state across the whole map
    chk("R2 irq", 32'(irq), 32'h0);
    for (int a = 0; a < 256; a += 4) begin
      brd(8'(a), d);
      chk("R2 zero map", d, 32'h0);
    end

    // R1: distinct reload values, exhaustive byte-address sweep
    for (int c = 0; c < NCH; c++) bwr(ca(c, 0), 32'h100 + 32'(c));
    for (int a = 0; a < 256; a++) begin
      brd(8'(a), d);
      if (a < NCH * 20 && (a % 20) == 0) chk("R1 map", d, 32'h100 + 32'(a / 20));
      else chk("R1 map", d, 32'h0);
    end

    // R3: control fields and readback
    bwr(ca(7, 8), 32'hFFFF_FFF8);
    brd(ca(7, 8), d);
    chk("R3 ctrl rb", d, 32'h10);
    bwr(ca(7, 8), 32'h0000_0014);
    brd(ca(7, 8), d);
    chk("R3 ctrl rb2", d, 32'h14);
    bwr(ca(7, 8), 32'h0);

    // R4/R9: start latency sweep per channel, reload mode
    for (int c = 0; c < NCH; c++) begin
      for (int L = 0; L < 6; L++) begin
        bwr(ca(c, 0), 32'(L));
        bwr(ca(c, 8), 32'h3);
        wait_irq(c, 40, k);
        chk("R4 latency", 32'(k), 32'(L + 2));
        chk("R8 only own irq", 32'(irq), 32'(1 << c));
        bwr(ca(c, 8), 32'h0);
        brd(ca(c, 12), d);
        chk("R9 eoi value", d, 32'h1);
        chk("R9 irq cleared", 32'(irq), 32'h0);
      end
    end

    // R6: wrap mode
    bwr(ca(3, 0), 32'd2);
    bwr(ca(3, 8), 32'h1);
    wait_irq(3, 40, k);
    chk("R6 latency", 32'(k), 32'd4);
    brd(ca(3, 4), d);
    chk("R6 wrap value", d, 32'hFFFF_FFFE);

    // R7: disable holds the count
    bwr(ca(3, 8), 32'h0);
    brd(ca(3, 4), v1);
    repeat (10) @(negedge clk);
    brd(ca(3, 4), v2);
    chk("R7 hold", v2, v1);
    // R11: write to live count ignored
    bwr(ca(3, 4), 32'hDEAD_BEEF);
    brd(ca(3, 4), v2);
    chk("R11 cur ro", v2, v1);
    brd(ca(3, 12), d);

    // R5: reload value rewritten mid-period
    bwr(ca(2, 0), 32'd100);
    bwr(ca(2, 8), 32'h3);
    repeat (5) @(negedge clk);
    bwr(ca(2, 0), 32'd3);
    brd(ca(2, 0), d);
    chk("R5 load rb", d, 32'd3);
    brd(ca(2, 4), d);
    chk("R5 count untouched", 32'(d > 32'd3 && d < 32'd100), 32'd1);
    wait_irq(2, 200, k);
    chk("R5 irq seen", 32'(irq[2]), 32'd1);
    brd(ca(2, 4), d);
    chk("R5 new reload", d, 32'd2);
    bwr(ca(2, 8), 32'h0);
    brd(ca(2, 12), d);

    // R8: masking
    bwr(ca(5, 0), 32'd3);
    bwr(ca(5, 8), 32'h7);
    repeat (10) @(negedge clk);
    chk("R8 masked irq", 32'(irq), 32'h0);
    brd(8'hA8, d);
    chk("R8 raw view", d, 32'h20);
    brd(8'hA0, d);
    chk("R8 masked view", d, 32'h0);
    brd(ca(5, 16), d);
    chk("R8 status masked", d, 32'h0);
    bwr(ca(5, 8), 32'h3);
    chk("R8 unmask irq", 32'(irq), 32'h20);
    brd(ca(5, 16), d);
    chk("R8 status", d, 32'h1);
    bwr(ca(5, 8), 32'h0);
    brd(ca(5, 12), d);

    // R9/R10/R11: per-channel and shared clearing
    bwr(ca(1, 0), 32'd2);
    bwr(ca(6, 0), 32'd2);
    bwr(ca(1, 8), 32'h3);
    bwr(ca(6, 8), 32'h3);
    repeat (10) @(negedge clk);
    bwr(ca(1, 8), 32'h0);
    bwr(ca(6, 8), 32'h0);
    bwr(ca(1, 12), 32'h1);
    bwr(ca(6, 16), 32'h0);
    bwr(8'hA4, 32'hFF);
    bwr(8'hA8, 32'h0);
    brd(8'hA8, d);
    chk("R11 writes clear nothing", d, 32'h42);
    brd(ca(1, 12), d);
    chk("R9 eoi ch1", d, 32'h1);
    brd(8'hA8, d);
    chk("R9 only ch1 cleared", d, 32'h40);
    bwr(ca(1, 8), 32'h3);
    repeat (8) @(negedge clk);
    bwr(ca(1, 8), 32'h0);
    brd(8'hA4, d);
    chk("R10 global eoi value", d, 32'h42);
    brd(8'hA8, d);
    chk("R10 all cleared", d, 32'h0);
    chk("R10 irq low", 32'(irq), 32'h0);

    summary();
    $finish;
  end
endmodule